// File: doc/BRIEF.md
# Coprocessor-0 Exception Entry Unit

This block holds the system-control registers of a small 32-bit CPU and carries out the register side of reset and exception entry. Its four registers are the status word, the cause word, the exception return address and a read-only processor identity. Reset loads fixed values and points the fetch address at the boot ROM.

When the pipeline raises an exception request, the block records the exception code and the two-bit branch-delay/branch-taken tag in the cause word. It saves a return address that backs up one instruction when the faulting instruction sits in a delay slot. It pushes the interrupt-enable/kernel-user stack in the status word. One cycle later it presents a fetch redirect to the handler vector, which is chosen by the boot-vector bit of the status word.

The block also combines an interrupt-status word with an interrupt-mask word. It takes an external interrupt as exception code 0 when both interrupt enables in the status word are set. A return-from-exception pulse pops the mode stack. Software reads the registers through an index port and may write the status word.

Top module: `cp0_exc_unit`

## Requirements
- R1: While rst_n is low, at each rising edge the block loads status = 0x10600000, cause = 0 and return address = 0. It also sets pc_next = 0xBFC00000 and pc_load = 0. Index 15 reads 0x00000002 at all times.
- R2: If cfg_cop2_en is 1 during reset, status bit 30 is also set, giving 0x50600000.
- R3: On entry, cause becomes {tag[1:0], 20 zero bits, old cause[9:8], 0, code[4:0], 00}. The tag comes from exc_bdt and sits in bits 31:30. The code sits in bits 6:2.
- R4: On entry, the return address becomes exc_pc - 4 when exc_bdt is nonzero, and exc_pc otherwise.
- R5: One cycle after the entry edge, pc_load is 1 for one cycle. pc_next then holds 0xBFC00180 if status bit 22 was 1 before entry, and 0x80000080 otherwise.
- R6: On entry, status bits 5:0 become {old bits 3:0, 00}. All other status bits are kept.
- R7: irq_take is 1 exactly when (irq_status & irq_mask) is nonzero, status bits 10 and 0 are both 1, and exc_req is 0. A taken interrupt enters with code 0.
- R8: When exc_req and an enabled pending interrupt occur in the same cycle, the request's own code is recorded and irq_take stays 0.
- R9: A rfe_pulse without entry loads status bits 3:0 from bits 5:2. Bits 5:4 and all higher bits are kept.
- R10: reg_rdata shows the value selected by reg_idx: 12 selects status, 13 cause, 14 return address, 15 identity, and any other index reads 0. A write at index 12 is visible from the next cycle. Writes at any other index change nothing.
- R11: In a cycle with entry, a status write is discarded. In a cycle with rfe_pulse and no entry, a status write is discarded and the pop is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cop2_en | input | 1 | Sets status bit 30 at reset |
| exc_req | input | 1 | Exception request from the pipeline |
| exc_code | input | 5 | Exception code of the request |
| exc_bdt | input | 2 | Branch-delay/taken tag of the current instruction |
| exc_pc | input | 32 | Address of the current instruction |
| rfe_pulse | input | 1 | Return-from-exception: pop the mode stack |
| irq_status | input | IRQ_W | Interrupt-status word |
| irq_mask | input | IRQ_W | Interrupt-mask word |
| reg_idx | input | 5 | Register index for read and write |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_take | output | 1 | External interrupt is taken this cycle |
| pc_load | output | 1 | Fetch redirect strobe |
| pc_next | output | 32 | Fetch redirect address |

## Verification
irq_take and reg_rdata are combinational, so each is due in the same cycle as its stimulus. The bench samples them a short delay after it drives inputs on the falling edge. The register updates from entry, pop and write land on the next rising edge, so they are read back at the following falling edge. The redirect is registered and due one cycle after the entry edge. Every entry pushes its expected vector into a queue, and a falling-edge monitor pops that queue whenever pc_load is seen. A redirect that never arrives leaves the queue non-empty at the end of the run, and an unexpected one finds the queue empty.

// File: rtl/cp0_pkg.sv
// Package: shared constants, field positions and stack helpers for the
// coprocessor-0 exception entry unit. Assumes a 32-bit data path.
package cp0_pkg;
    localparam int XLEN = 32;
    localparam int IDX_W = 5;
    localparam int CODE_W = 5;
    localparam int TAG_W = 2;

    // Register index map seen by software
    localparam logic [IDX_W-1:0] IDX_SR    = 5'd12;
    localparam logic [IDX_W-1:0] IDX_CAUSE = 5'd13;
    localparam logic [IDX_W-1:0] IDX_EPC   = 5'd14;
    localparam logic [IDX_W-1:0] IDX_PRID  = 5'd15;

    // Status bit positions the behaviour depends on
    localparam int SR_IE_BIT   = 0;
    localparam int SR_IM_BIT   = 10;
    localparam int SR_BEV_BIT  = 22;
    localparam int SR_COP2_BIT = 30;

    typedef logic [XLEN-1:0] word_t;

    // Push the IE/KU stack one level deeper and clear the current pair
    function automatic word_t sr_push(input word_t s);
        return {s[XLEN-1:6], s[3:0], 2'b00};
    endfunction

    // Pop the IE/KU stack one level; the oldest pair is kept
    function automatic word_t sr_pop(input word_t s);
        return {s[XLEN-1:4], s[5:2]};
    endfunction
endpackage

// File: rtl/cp0_irq_eval.sv
// Module: external interrupt evaluation. Combinational.
// An interrupt is pending when any status bit meets a mask bit. It is taken
// only when both status enables are set and no exception request competes.
module cp0_irq_eval #(
    parameter int IRQ_W = 32
) (
    input  logic [IRQ_W-1:0] irq_status,
    input  logic [IRQ_W-1:0] irq_mask,
    input  logic             en_master,
    input  logic             en_global,
    input  logic             exc_req,
    output logic             take
);
    logic pending;

    // Pending detection and take qualification
    always_comb begin
        pending = |(irq_status & irq_mask);
        take    = pending && en_master && en_global && !exc_req;
    end
endmodule

// File: rtl/cp0_status_reg.sv
// Module: status register with reset load, mode-stack push and pop, and
// software write. Priority: entry, then pop, then software write.
// Assumes a synchronous active-low reset.
module cp0_status_reg
    import cp0_pkg::*;
#(
    parameter word_t RESET_SR = 32'h1060_0000
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cfg_cop2_en,
    input  logic  entry,
    input  logic  pop,
    input  logic  wr_en,
    input  word_t wr_data,
    output word_t sr
);
    localparam word_t COP2_MASK = word_t'(1) << SR_COP2_BIT;

    // Status update with fixed priority
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr <= cfg_cop2_en ? (RESET_SR | COP2_MASK) : RESET_SR;
        else if (entry)
            sr <= sr_push(sr);
        else if (pop)
            sr <= sr_pop(sr);
        else if (wr_en)
            sr <= wr_data;
    end
endmodule

// File: rtl/cp0_cause_epc.sv
// Module: cause and return-address capture on exception entry.
// Keeps cause bits 9:8 across entries. Backs the return address up one
// instruction when the branch tag is nonzero. Synchronous active-low reset.
module cp0_cause_epc
    import cp0_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              entry,
    input  logic [CODE_W-1:0] code,
    input  logic [TAG_W-1:0]  tag,
    input  word_t             pc,
    output word_t             cause,
    output word_t             epc
);
    localparam int GAP_W = XLEN - TAG_W - 10;

    // Cause capture: tag on top, kept bits 9:8, code at 6:2
    always_ff @(posedge clk) begin
        if (!rst_n)
            cause <= '0;
        else if (entry)
            cause <= {tag, {GAP_W{1'b0}}, cause[9:8], 1'b0, code, 2'b00};
    end

    // Return address capture
    always_ff @(posedge clk) begin
        if (!rst_n)
            epc <= '0;
        else if (entry)
            epc <= (tag != '0) ? (pc - word_t'(4)) : pc;
    end
endmodule

// File: rtl/cp0_redirect.sv
// Module: fetch redirect generation. Registers a one-cycle load strobe and
// the handler vector selected by the boot-vector bit before entry.
// Holds the reset address until the first entry.
module cp0_redirect
    import cp0_pkg::*;
#(
    parameter word_t RESET_PC = 32'hBFC0_0000,
    parameter word_t BOOT_VEC = 32'hBFC0_0180,
    parameter word_t RAM_VEC  = 32'h8000_0080
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  entry,
    input  logic  bev,
    output logic  pc_load,
    output word_t pc_next
);
    // Redirect strobe and address register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_load <= 1'b0;
            pc_next <= RESET_PC;
        end else begin
            pc_load <= entry;
            if (entry)
                pc_next <= bev ? BOOT_VEC : RAM_VEC;
        end
    end
endmodule

// File: rtl/cp0_exc_unit.sv
// Module: top of the coprocessor-0 exception entry unit.
// Combines interrupt evaluation, the status register, cause/return-address
// capture and redirect generation, and serves the register index port.
// Assumes exc_pc and exc_bdt describe the current instruction in every
// cycle, so an interrupt entry can use them.
module cp0_exc_unit
    import cp0_pkg::*;
#(
    parameter int    IRQ_W    = 32,
    parameter word_t RESET_PC = 32'hBFC0_0000,
    parameter word_t BOOT_VEC = 32'hBFC0_0180,
    parameter word_t RAM_VEC  = 32'h8000_0080,
    parameter word_t RESET_SR = 32'h1060_0000,
    parameter word_t PRID_VAL = 32'h0000_0002
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_cop2_en,
    input  logic             exc_req,
    input  logic [4:0]       exc_code,
    input  logic [1:0]       exc_bdt,
    input  logic [31:0]      exc_pc,
    input  logic             rfe_pulse,
    input  logic [IRQ_W-1:0] irq_status,
    input  logic [IRQ_W-1:0] irq_mask,
    input  logic [4:0]       reg_idx,
    input  logic             reg_wr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             irq_take,
    output logic             pc_load,
    output logic [31:0]      pc_next
);
    word_t             sr_q;
    word_t             cause_q;
    word_t             epc_q;
    logic              entry;
    logic [CODE_W-1:0] entry_code;
    logic              sr_wr;

    cp0_irq_eval #(.IRQ_W(IRQ_W)) u_irq (
        .irq_status (irq_status),
        .irq_mask   (irq_mask),
        .en_master  (sr_q[SR_IM_BIT]),
        .en_global  (sr_q[SR_IE_BIT]),
        .exc_req    (exc_req),
        .take       (irq_take)
    );

    // Entry source and code selection; the request outranks the interrupt
    always_comb begin
        entry      = exc_req || irq_take;
        entry_code = exc_req ? exc_code : '0;
        sr_wr      = reg_wr && (reg_idx == IDX_SR);
    end

    cp0_status_reg #(.RESET_SR(RESET_SR)) u_sr (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_cop2_en (cfg_cop2_en),
        .entry       (entry),
        .pop         (rfe_pulse),
        .wr_en       (sr_wr),
        .wr_data     (reg_wdata),
        .sr          (sr_q)
    );

    cp0_cause_epc u_ce (
        .clk   (clk),
        .rst_n (rst_n),
        .entry (entry),
        .code  (entry_code),
        .tag   (exc_bdt),
        .pc    (exc_pc),
        .cause (cause_q),
        .epc   (epc_q)
    );

    cp0_redirect #(
        .RESET_PC (RESET_PC),
        .BOOT_VEC (BOOT_VEC),
        .RAM_VEC  (RAM_VEC)
    ) u_redir (
        .clk     (clk),
        .rst_n   (rst_n),
        .entry   (entry),
        .bev     (sr_q[SR_BEV_BIT]),
        .pc_load (pc_load),
        .pc_next (pc_next)
    );

    // Read multiplexer for the index port
    always_comb begin
        case (reg_idx)
            IDX_SR:    reg_rdata = sr_q;
            IDX_CAUSE: reg_rdata = cause_q;
            IDX_EPC:   reg_rdata = epc_q;
            IDX_PRID:  reg_rdata = PRID_VAL;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cp0_exc_chk.sv
// Module: assertion checker for the exception entry unit, bound to the top.
// Observes ports and the three architectural registers.
module cp0_exc_chk #(
    parameter logic [31:0] BOOT_VEC = 32'hBFC0_0180,
    parameter logic [31:0] RAM_VEC  = 32'h8000_0080
) (
    input logic        clk,
    input logic        rst_n,
    input logic        exc_req,
    input logic        irq_take,
    input logic [1:0]  exc_bdt,
    input logic [31:0] exc_pc,
    input logic        rfe_pulse,
    input logic        pc_load,
    input logic [31:0] pc_next,
    input logic [31:0] sr,
    input logic [31:0] cause,
    input logic [31:0] epc
);
    // R3
    tag_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req || irq_take) |=> cause[31:30] == $past(exc_bdt));

    // R4
    epc_backup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req || irq_take) |=> epc == (($past(exc_bdt) != 2'b00) ?
                                          $past(exc_pc) - 32'd4 : $past(exc_pc)));

    // R5
    redirect_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req || irq_take) |=> pc_load);

    // R5
    redirect_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> (pc_next == BOOT_VEC || pc_next == RAM_VEC));

    // R6
    stack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req || irq_take) |=> (sr[5:0] == {$past(sr[3:0]), 2'b00}) &&
                                  (sr[31:6] == $past(sr[31:6])));

    // R8
    req_over_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> !irq_take);

    // R9
    stack_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rfe_pulse && !exc_req && !irq_take) |=>
            (sr[3:0] == $past(sr[5:2])) && (sr[31:4] == $past(sr[31:4])));
endmodule

bind cp0_exc_unit cp0_exc_chk #(
    .BOOT_VEC (BOOT_VEC),
    .RAM_VEC  (RAM_VEC)
) u_cp0_exc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .exc_req   (exc_req),
    .irq_take  (irq_take),
    .exc_bdt   (exc_bdt),
    .exc_pc    (exc_pc),
    .rfe_pulse (rfe_pulse),
    .pc_load   (pc_load),
    .pc_next   (pc_next),
    .sr        (sr_q),
    .cause     (cause_q),
    .epc       (epc_q)
);

// File: tb/test_cp0_exc_unit.sv
// Scoreboard bench: the driver pushes expected redirect vectors into a queue,
// and a falling-edge monitor pops and compares them when pc_load appears.
module test_cp0_exc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_cop2_en = 1'b0;
    logic        exc_req = 1'b0;
    logic [4:0]  exc_code = '0;
    logic [1:0]  exc_bdt = '0;
    logic [31:0] exc_pc = '0;
    logic        rfe_pulse = 1'b0;
    logic [31:0] irq_status = '0;
    logic [31:0] irq_mask = '0;
    logic [4:0]  reg_idx = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_take;
    logic        pc_load;
    logic [31:0] pc_next;

    int n_tests = 0;
    int n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] m_sr, m_cause, m_epc;

    always #4 clk = ~clk;

    cp0_exc_unit i_cp0_exc_unit (
        .clk(clk), .rst_n(rst_n), .cfg_cop2_en(cfg_cop2_en),
        .exc_req(exc_req), .exc_code(exc_code), .exc_bdt(exc_bdt), .exc_pc(exc_pc),
        .rfe_pulse(rfe_pulse), .irq_status(irq_status), .irq_mask(irq_mask),
        .reg_idx(reg_idx), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_take(irq_take), .pc_load(pc_load), .pc_next(pc_next)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: each redirect must match the oldest expected vector
    always @(negedge clk) begin
        if (rst_n && pc_load === 1'b1) begin
            if (exp_q.size() == 0) begin
                n_tests++;
                n_fail++;
                $display("FAIL R5 unexpected redirect actual=%h expected=none", pc_next);
            end else begin
                chk(tag_q.pop_front(), pc_next, exp_q.pop_front());
            end
        end
    end

    task automatic rd(input logic [4:0] idx, input logic [31:0] exp, input string tag);
        reg_idx = idx;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic check_regs(input string tag);
        rd(5'd12, m_sr, {tag, " status"});
        rd(5'd13, m_cause, {tag, " cause"});
        rd(5'd14, m_epc, {tag, " epc"});
    endtask

    task automatic do_reset(input logic cop2);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_cop2_en = cop2;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_sr = cop2 ? 32'h5060_0000 : 32'h1060_0000;
        m_cause = '0;
        m_epc = '0;
    endtask

    // Driver: applies one cycle of stimulus and updates the model per the requirements
    task automatic drive(input logic exc, input logic [4:0] code, input logic [1:0] bdt,
                         input logic [31:0] pc, input logic rfe, input logic wr,
                         input logic [4:0] widx, input logic [31:0] wd,
                         input logic [31:0] st, input logic [31:0] mk, input string tag);
        logic exp_irq;
        logic entry;
        logic [4:0] ecode;
        @(negedge clk);
        exc_req = exc; exc_code = code; exc_bdt = bdt; exc_pc = pc;
        rfe_pulse = rfe; reg_wr = wr; reg_idx = widx; reg_wdata = wd;
        irq_status = st; irq_mask = mk;
        #1;
        exp_irq = ((st & mk) != 0) && m_sr[10] && m_sr[0] && !exc;
        chk({tag, " R7 irq_take"}, {31'd0, irq_take}, {31'd0, exp_irq});
        if (wr && widx == 5'd12)
            chk({tag, " R10 write not yet visible"}, reg_rdata, m_sr);
        entry = exc || exp_irq;
        ecode = exc ? code : 5'd0;
        if (entry) begin
            exp_q.push_back(m_sr[22] ? 32'hBFC0_0180 : 32'h8000_0080);
            tag_q.push_back({tag, " R5 redirect"});
            m_cause = {bdt, 20'd0, m_cause[9:8], 1'b0, ecode, 2'b00};
            m_epc = (bdt != 2'b00) ? pc - 32'd4 : pc;
            m_sr = {m_sr[31:6], m_sr[3:0], 2'b00};
        end else if (rfe) begin
            m_sr = {m_sr[31:4], m_sr[5:2]};
        end else if (wr && widx == 5'd12) begin
            m_sr = wd;
        end
        @(negedge clk);
        exc_req = 1'b0; rfe_pulse = 1'b0; reg_wr = 1'b0;
        irq_status = '0; irq_mask = '0;
    endtask

    initial begin
        #(8 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset(1'b0);
        #1;
        chk("R1 pc_next", pc_next, 32'hBFC0_0000);
        chk("R1 pc_load", {31'd0, pc_load}, 32'd0);
        check_regs("R1");
        rd(5'd15, 32'h0000_0002, "R1 identity");
        rd(5'd3, 32'h0, "R10 unmapped index");

        // R2 coprocessor-2 usable bit at reset
        do_reset(1'b1);
        rd(5'd12, 32'h5060_0000, "R2 status");
        cfg_cop2_en = 1'b0;

        // R10 status write, then R3/R4/R5/R6 entry with boot vector, tag 0
        drive(0, 0, 0, 0, 0, 1, 5'd12, 32'h1060_000F, 0, 0, "R10 write");
        check_regs("R10");
        drive(1, 5'd5, 2'b00, 32'h0000_1000, 0, 0, 0, 0, 0, 0, "R3 R4 R6 boot");
        check_regs("R3 R4 R6 boot");

        // R9 pop
        drive(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R9 pop");
        check_regs("R9 pop");

        // R5 RAM vector, R4 backup with tag 2
        drive(0, 0, 0, 0, 0, 1, 5'd12, 32'h1000_0405, 0, 0, "R10 write b");
        drive(1, 5'd12, 2'b10, 32'h0000_2000, 0, 0, 0, 0, 0, 0, "R4 R5 ram");
        check_regs("R4 R5 ram");

        // R7 taken interrupt with tag 1
        drive(0, 0, 0, 0, 0, 1, 5'd12, 32'h1000_0401, 0, 0, "R10 write c");
        drive(0, 5'd9, 2'b01, 32'h0000_3000, 0, 0, 0, 0, 32'h10, 32'h30, "R7 taken");
        check_regs("R7 taken");

        // R7 not taken: master enable clear, then disjoint mask
        drive(0, 0, 0, 0, 0, 1, 5'd12, 32'h1000_0001, 0, 0, "R10 write d");
        drive(0, 0, 0, 32'h4000, 0, 0, 0, 0, 32'hFF, 32'hFF, "R7 master off");
        check_regs("R7 master off");
        drive(0, 0, 0, 0, 0, 1, 5'd12, 32'h1000_0401, 0, 0, "R10 write e");
        drive(0, 0, 0, 32'h4000, 0, 0, 0, 0, 32'h1, 32'h2, "R7 disjoint");
        check_regs("R7 disjoint");

        // R8 request over pending interrupt
        drive(1, 5'd8, 2'b00, 32'h0000_5000, 0, 0, 0, 0, 32'h4, 32'h4, "R8 priority");
        check_regs("R8 priority");

        // R11 entry beats a status write; pop beats a status write
        drive(1, 5'd4, 2'b11, 32'h0000_6000, 0, 1, 5'd12, 32'hFFFF_FFFF, 0, 0, "R11 entry vs write");
        check_regs("R11 entry vs write");
        drive(0, 0, 0, 0, 1, 1, 5'd12, 32'h0000_0000, 0, 0, "R11 pop vs write");
        check_regs("R11 pop vs write");

        // R10 writes at other indices are ignored
        drive(0, 0, 0, 0, 0, 1, 5'd13, 32'hDEAD_BEEF, 0, 0, "R10 cause write");
        drive(0, 0, 0, 0, 0, 1, 5'd14, 32'hDEAD_BEEF, 0, 0, "R10 epc write");
        drive(0, 0, 0, 0, 0, 1, 5'd15, 32'hDEAD_BEEF, 0, 0, "R10 id write");
        check_regs("R10 ignored writes");
        rd(5'd15, 32'h0000_0002, "R10 identity");

        repeat (3) @(negedge clk);
        chk("R5 outstanding redirects", exp_q.size(), 32'd0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule